// File: doc/BRIEF.md
# Packed Word Dot-Product Saturating Accumulator

This block is a SIMD datapath built from 32-bit lanes. Each lane holds two signed 16-bit elements in each of two source vectors. The block multiplies the matching elements of the two sources, adds both products to the lane's current signed 32-bit accumulator, and clamps the exact total to the signed 32-bit range. All lanes are computed from the accumulator vector exactly as it was presented, so no lane sees another lane's update.

Around this core, per-lane control decides what each lane writes:

- A vector-length code decides how many lanes take part. Every lane above that count is written as zero.
- A lane mask, when masking is switched on, marks the inactive lanes. Each inactive lane either keeps its accumulator or is cleared, depending on a zeroing select.
- A broadcast select replaces each lane's second-source dword with a single 32-bit value that is shared by all lanes.

An operation is offered with `in_valid`. Its result is registered and appears one cycle later together with `out_valid`.

Top module: `wdot_sat_acc`

## Requirements
- R1: For an active lane i, the element at bits [32i+15:32i] of `src_a` is multiplied by bits [15:0] of that lane's second operand dword, and bits [32i+31:32i+16] of `src_a` by bits [31:16]. All four values are signed 16-bit. The lane result is the accumulator dword plus both products.
- R2: If the exact total of R1 is above 2^31-1, the lane result is 0x7FFF_FFFF.
- R3: If the exact total of R1 is below -2^31, the lane result is 0x8000_0000.
- R4: `vlen_sel` sets the lane count: 2'b00 gives the lowest 4 lanes (128 bits), 2'b01 the lowest 8 (256 bits), and 2'b10 or 2'b11 all 16 (512 bits). Every lane at or above the count is zero in `result`, whatever the mask settings.
- R5: With `mask_on`=1 and `zero_mode`=0, a lane within the count whose `lane_mask` bit is 0 outputs its `acc_in` dword unchanged.
- R6: With `mask_on`=1 and `zero_mode`=1, a lane within the count whose `lane_mask` bit is 0 outputs zero.
- R7: With `mask_on`=0, every lane within the count is active, whatever the value of `lane_mask`.
- R8: With `bcast_en`=1, every lane uses `bcast_dw` as its second operand dword, and `src_b` has no effect.
- R9: `out_valid` is `in_valid` delayed by one cycle, and `result` for an accepted operation appears in that same cycle. While `in_valid` is 0, `result` holds its value.
- R10: Synchronous active-high `rst` clears `out_valid` and `result` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered this cycle |
| mask_on | input | 1 | 1: apply lane_mask; 0: all lanes active |
| zero_mode | input | 1 | Masked-off lanes: 1 clear, 0 keep accumulator |
| bcast_en | input | 1 | Use bcast_dw as every lane's second operand |
| vlen_sel | input | 2 | Vector length code (see R4) |
| lane_mask | input | LANES | Per-lane active bit |
| acc_in | input | LANES*2*ELEM_W | Accumulator vector |
| src_a | input | LANES*2*ELEM_W | First source word pairs |
| src_b | input | LANES*2*ELEM_W | Second source word pairs |
| bcast_dw | input | 2*ELEM_W | Shared second-operand dword |
| out_valid | output | 1 | Result valid |
| result | output | LANES*2*ELEM_W | Updated destination vector |

## Verification
A table of ten lane patterns is rotated across all sixteen lanes. It covers small mixed-sign sums, both products at (-32768)*(-32768) on top of the positive limit, totals that land exactly on either limit against totals that pass it by one, and an opposite-sign pair that stays in range. Together these separate a correct 34-bit overflow test from one that uses a narrower sum, that ignores the sign, or that swaps the element pairing. Random vectors are then run under each vector-length code, under masking in merge mode and in zeroing mode, with masking switched off while every mask bit is clear, and with broadcast on while `src_b` carries noise. These runs show whether the length cut, the merge and zero choices and the operand source are applied to the correct lanes. A cycle with `in_valid` low checks that the result holds.

// File: rtl/wdot_pkg.sv
package wdot_pkg;

  typedef enum logic [1:0] {
    VL_QUARTER  = 2'b00,
    VL_HALF     = 2'b01,
    VL_FULL     = 2'b10,
    VL_FULL_ALT = 2'b11
  } vlen_e;

  typedef enum logic [1:0] {
    LANE_CALC = 2'b00,
    LANE_KEEP = 2'b01,
    LANE_ZERO = 2'b10
  } lane_act_e;

endpackage

// File: rtl/wdot_lane_mac.sv
module wdot_lane_mac #(
  parameter int ELEM_W = 16
) (
  input  logic [2*ELEM_W-1:0] acc,
  input  logic [2*ELEM_W-1:0] a_pair,
  input  logic [2*ELEM_W-1:0] b_pair,
  output logic [2*ELEM_W-1:0] sat_out
);
  localparam int DW    = 2 * ELEM_W;
  localparam int SUM_W = DW + 2;
  localparam int TOP_W = SUM_W - DW + 1;

  logic signed [ELEM_W-1:0] a_lo, a_hi, b_lo, b_hi;
  logic signed [DW-1:0]     p_lo, p_hi;
  logic signed [SUM_W-1:0]  total;
  logic [TOP_W-1:0]         top_bits;
  logic                     pos_ovf, neg_ovf;

  assign a_lo = a_pair[ELEM_W-1:0];
  assign a_hi = a_pair[DW-1:ELEM_W];
  assign b_lo = b_pair[ELEM_W-1:0];
  assign b_hi = b_pair[DW-1:ELEM_W];

  assign p_lo = a_lo * b_lo;
  assign p_hi = a_hi * b_hi;

  // exact sum: three terms of at most DW bits fit in DW+2 bits
  assign total = {{(SUM_W-DW){acc[DW-1]}},  acc}
               + {{(SUM_W-DW){p_lo[DW-1]}}, p_lo}
               + {{(SUM_W-DW){p_hi[DW-1]}}, p_hi};

  // in range only when the bits from the dword sign upward all agree
  assign top_bits = total[SUM_W-1:DW-1];
  assign pos_ovf  = !top_bits[TOP_W-1] && (|top_bits);
  assign neg_ovf  =  top_bits[TOP_W-1] && !(&top_bits);

  always_comb begin
    if (pos_ovf)      sat_out = {1'b0, {(DW-1){1'b1}}};
    else if (neg_ovf) sat_out = {1'b1, {(DW-1){1'b0}}};
    else              sat_out = total[DW-1:0];
  end
endmodule

// File: rtl/wdot_lane_ctrl.sv
module wdot_lane_ctrl
  import wdot_pkg::*;
#(
  parameter int LANES = 16
) (
  input  logic [1:0]       vlen_sel,
  input  logic [LANES-1:0] lane_mask,
  input  logic             mask_on,
  input  logic             zero_mode,
  output lane_act_e        lane_act [LANES]
);
  localparam int Q_LANES = LANES / 4;
  localparam int H_LANES = LANES / 2;

  for (genvar g = 0; g < LANES; g++) begin : g_ctl
    localparam bit IN_Q = (g < Q_LANES);
    localparam bit IN_H = (g < H_LANES);
    logic live, active;

    always_comb begin
      case (vlen_e'(vlen_sel))
        VL_QUARTER: live = IN_Q;
        VL_HALF:    live = IN_H;
        default:    live = 1'b1;
      endcase
    end

    assign active = !mask_on || lane_mask[g];

    always_comb begin
      if (!live)           lane_act[g] = LANE_ZERO;
      else if (active)     lane_act[g] = LANE_CALC;
      else if (zero_mode)  lane_act[g] = LANE_ZERO;
      else                 lane_act[g] = LANE_KEEP;
    end
  end
endmodule

// File: rtl/wdot_bsrc_mux.sv
module wdot_bsrc_mux #(
  parameter int LANES  = 16,
  parameter int ELEM_W = 16
) (
  input  logic                      bcast_en,
  input  logic [LANES*2*ELEM_W-1:0] src_b,
  input  logic [2*ELEM_W-1:0]       bcast_dw,
  output logic [LANES*2*ELEM_W-1:0] b_eff
);
  localparam int DW = 2 * ELEM_W;

  for (genvar g = 0; g < LANES; g++) begin : g_sel
    assign b_eff[g*DW +: DW] = bcast_en ? bcast_dw : src_b[g*DW +: DW];
  end
endmodule

// File: rtl/wdot_sat_acc.sv
module wdot_sat_acc
  import wdot_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int ELEM_W = 16
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      in_valid,
  input  logic                      mask_on,
  input  logic                      zero_mode,
  input  logic                      bcast_en,
  input  logic [1:0]                vlen_sel,
  input  logic [LANES-1:0]          lane_mask,
  input  logic [LANES*2*ELEM_W-1:0] acc_in,
  input  logic [LANES*2*ELEM_W-1:0] src_a,
  input  logic [LANES*2*ELEM_W-1:0] src_b,
  input  logic [2*ELEM_W-1:0]       bcast_dw,
  output logic                      out_valid,
  output logic [LANES*2*ELEM_W-1:0] result
);
  localparam int DW    = 2 * ELEM_W;
  localparam int VEC_W = LANES * DW;

  logic [VEC_W-1:0] b_eff;
  logic [VEC_W-1:0] next_vec;
  lane_act_e        lane_act [LANES];

  wdot_bsrc_mux #(.LANES(LANES), .ELEM_W(ELEM_W)) u_bsrc (
    .bcast_en (bcast_en),
    .src_b    (src_b),
    .bcast_dw (bcast_dw),
    .b_eff    (b_eff)
  );

  wdot_lane_ctrl #(.LANES(LANES)) u_ctrl (
    .vlen_sel  (vlen_sel),
    .lane_mask (lane_mask),
    .mask_on   (mask_on),
    .zero_mode (zero_mode),
    .lane_act  (lane_act)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [DW-1:0] mac_out;

    wdot_lane_mac #(.ELEM_W(ELEM_W)) u_mac (
      .acc     (acc_in[g*DW +: DW]),
      .a_pair  (src_a[g*DW +: DW]),
      .b_pair  (b_eff[g*DW +: DW]),
      .sat_out (mac_out)
    );

    always_comb begin
      case (lane_act[g])
        LANE_CALC: next_vec[g*DW +: DW] = mac_out;
        LANE_KEEP: next_vec[g*DW +: DW] = acc_in[g*DW +: DW];
        default:   next_vec[g*DW +: DW] = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_vec;
    end
  end
endmodule

// File: rtl/wdot_sat_acc_chk.sv
module wdot_sat_acc_chk #(
  parameter int LANES  = 16,
  parameter int ELEM_W = 16
) (
  input logic                      clk,
  input logic                      rst,
  input logic                      in_valid,
  input logic                      mask_on,
  input logic                      zero_mode,
  input logic [1:0]                vlen_sel,
  input logic                      mask0,
  input logic [2*ELEM_W-1:0]       acc0,
  input logic [2*ELEM_W-1:0]       a0,
  input logic                      out_valid,
  input logic [LANES*2*ELEM_W-1:0] result
);
  localparam int DW    = 2 * ELEM_W;
  localparam int VEC_W = LANES * DW;

  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk) begin
    if (rst_q === 1'b1) begin
      assert_reset_clear_R10: assert (!out_valid && result == '0);
    end
  end

  assert_valid_follows_R9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  assert_valid_drops_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  assert_result_holds_R9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));

  assert_upper_cleared_R4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && vlen_sel == 2'b00) |=> (result[VEC_W-1:VEC_W/4] == '0));

  assert_merge_keeps_R5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_on && !zero_mode && !mask0) |=> (result[DW-1:0] == $past(acc0)));

  assert_zeroing_clears_R6: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mask_on && zero_mode && !mask0) |=> (result[DW-1:0] == '0));

  assert_zero_products_R1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (!mask_on || mask0) && a0 == '0) |=> (result[DW-1:0] == $past(acc0)));
endmodule

bind wdot_sat_acc wdot_sat_acc_chk #(.LANES(LANES), .ELEM_W(ELEM_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .mask_on   (mask_on),
  .zero_mode (zero_mode),
  .vlen_sel  (vlen_sel),
  .mask0     (lane_mask[0]),
  .acc0      (acc_in[2*ELEM_W-1:0]),
  .a0        (src_a[2*ELEM_W-1:0]),
  .out_valid (out_valid),
  .result    (result)
);

// File: tb/wdot_sat_acc_bench.sv
module wdot_sat_acc_bench;
  localparam int CLK_PERIOD = 10;
  localparam int LANES = 16;
  localparam int ELEM_W = 16;
  localparam int DW = 2 * ELEM_W;
  localparam int VEC_W = LANES * DW;
  localparam int NROWS = 10;

  // {acc, a_pair, b_pair, expected}
  localparam logic [127:0] VEC_TAB [NROWS] = '{
    {32'h0000_0000, 32'h0003_0002, 32'h0005_0004, 32'h0000_0017},
    {32'h0000_0064, 32'h0001_FFFF, 32'h0009_0007, 32'h0000_0066},
    {32'h7FFF_FFFF, 32'h8000_8000, 32'h8000_8000, 32'h7FFF_FFFF},
    {32'h8000_0000, 32'h8000_8000, 32'h7FFF_7FFF, 32'h8000_0000},
    {32'h7FFF_FFF0, 32'h0000_0004, 32'h0000_0004, 32'h7FFF_FFFF},
    {32'h7FFF_FFF0, 32'h0000_0003, 32'h0000_0005, 32'h7FFF_FFFF},
    {32'h8000_0010, 32'h0000_FFFC, 32'h0000_0004, 32'h8000_0000},
    {32'h8000_0010, 32'hFFFF_FFFC, 32'h0001_0004, 32'h8000_0000},
    {32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0000_0001},
    {32'h1234_5678, 32'h8000_7FFF, 32'h7FFF_8000, 32'h9235_5678}
  };

  logic clk = 1'b0;
  logic rst, in_valid, mask_on, zero_mode, bcast_en;
  logic [1:0] vlen_sel;
  logic [LANES-1:0] lane_mask;
  logic [VEC_W-1:0] acc_in, src_a, src_b, result;
  logic [DW-1:0] bcast_dw;
  logic out_valid;

  int n_checks = 0;
  int n_err = 0;
  logic [31:0] seed = 32'h1357_9BDF;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdot_sat_acc #(.LANES(LANES), .ELEM_W(ELEM_W)) u_wdot_sat_acc (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mask_on(mask_on),
    .zero_mode(zero_mode), .bcast_en(bcast_en), .vlen_sel(vlen_sel),
    .lane_mask(lane_mask), .acc_in(acc_in), .src_a(src_a), .src_b(src_b),
    .bcast_dw(bcast_dw), .out_valid(out_valid), .result(result)
  );

  function automatic logic [31:0] rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed ^ (seed >> 13);
  endfunction

  function automatic logic [31:0] lane_ref(input logic [31:0] acc, a, b);
    longint s;
    s = longint'($signed(acc))
      + longint'($signed(a[15:0])) * longint'($signed(b[15:0]))
      + longint'($signed(a[31:16])) * longint'($signed(b[31:16]));
    if (s > 64'sd2147483647) return 32'h7FFF_FFFF;
    if (s < -64'sd2147483648) return 32'h8000_0000;
    return s[31:0];
  endfunction

  function automatic logic [VEC_W-1:0] model();
    logic [VEC_W-1:0] v;
    int n;
    n = (vlen_sel == 2'b00) ? LANES/4 : (vlen_sel == 2'b01) ? LANES/2 : LANES;
    for (int i = 0; i < LANES; i++) begin
      logic [31:0] b;
      b = bcast_en ? bcast_dw : src_b[i*DW +: DW];
      if (i >= n)                         v[i*DW +: DW] = '0;
      else if (!mask_on || lane_mask[i])  v[i*DW +: DW] = lane_ref(acc_in[i*DW +: DW], src_a[i*DW +: DW], b);
      else if (zero_mode)                 v[i*DW +: DW] = '0;
      else                                v[i*DW +: DW] = acc_in[i*DW +: DW];
    end
    return v;
  endfunction

  task automatic check32(input string req, input int lane, input logic [31:0] got, exp);
    n_checks++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s lane %0d: got %h expected %h", req, lane, got, exp);
    end
  endtask

  task automatic check_bit(input string req, input logic got, exp);
    n_checks++;
    if (got !== exp) begin
      n_err++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic fill_random();
    for (int i = 0; i < LANES; i++) begin
      acc_in[i*DW +: DW] = rnd();
      src_a[i*DW +: DW]  = rnd();
      src_b[i*DW +: DW]  = rnd();
    end
    bcast_dw = rnd();
  endtask

  // called at a negedge with inputs set; checks the registered result one cycle later
  task automatic run_case(input string req, input logic [1:0] vl, input logic mon,
                          input logic zm, input logic bc, input logic [LANES-1:0] msk);
    logic [VEC_W-1:0] exp;
    fill_random();
    vlen_sel = vl; mask_on = mon; zero_mode = zm; bcast_en = bc; lane_mask = msk;
    exp = model();
    in_valid = 1'b1;
    @(negedge clk);
    check_bit({req, " out_valid"}, out_valid, 1'b1);
    for (int i = 0; i < LANES; i++) check32(req, i, result[i*DW +: DW], exp[i*DW +: DW]);
    in_valid = 1'b0;
  endtask

  function automatic string tag_of(input int row);
    if (row == 2 || row == 4 || row == 5) return "R2";
    if (row == 3 || row == 6 || row == 7) return "R3";
    return "R1";
  endfunction

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    rst = 1'b1; in_valid = 1'b0; mask_on = 1'b0; zero_mode = 1'b0; bcast_en = 1'b0;
    vlen_sel = 2'b10; lane_mask = '0; acc_in = '0; src_a = '0; src_b = '0; bcast_dw = '0;
    repeat (3) @(negedge clk);
    // R10: reset state
    check_bit("R10 out_valid", out_valid, 1'b0);
    check32("R10 result", 0, 32'(result != '0), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check_bit("R9 idle out_valid", out_valid, 1'b0);

    // table walk, rows rotated across lanes (R1, R2, R3)
    for (int r = 0; r < NROWS; r++) begin
      logic [VEC_W-1:0] exp;
      for (int j = 0; j < LANES; j++) begin
        int k;
        k = (r + j) % NROWS;
        acc_in[j*DW +: DW] = VEC_TAB[k][127:96];
        src_a[j*DW +: DW]  = VEC_TAB[k][95:64];
        src_b[j*DW +: DW]  = VEC_TAB[k][63:32];
        exp[j*DW +: DW]    = VEC_TAB[k][31:0];
      end
      mask_on = 1'b0; bcast_en = 1'b0; vlen_sel = 2'b10; lane_mask = '1;
      in_valid = 1'b1;
      @(negedge clk);
      check_bit("R9 out_valid", out_valid, 1'b1);
      for (int j = 0; j < LANES; j++)
        check32(tag_of((r + j) % NROWS), j, result[j*DW +: DW], exp[j*DW +: DW]);
      in_valid = 1'b0;
    end

    // R9: result holds while in_valid is low
    begin
      logic [VEC_W-1:0] held;
      held = result;
      fill_random();
      @(negedge clk);
      check_bit("R9 out_valid low", out_valid, 1'b0);
      for (int i = 0; i < LANES; i++) check32("R9 hold", i, result[i*DW +: DW], held[i*DW +: DW]);
    end

    run_case("R4 len128",       2'b00, 1'b0, 1'b0, 1'b0, '1);
    run_case("R4 len256",       2'b01, 1'b0, 1'b0, 1'b0, '1);
    run_case("R4 len512alt",    2'b11, 1'b0, 1'b0, 1'b0, '1);
    run_case("R4 len128 merge", 2'b00, 1'b1, 1'b0, 1'b0, 16'h0000);
    run_case("R5 merge",        2'b10, 1'b1, 1'b0, 1'b0, 16'hA5A4);
    run_case("R6 zeroing",      2'b10, 1'b1, 1'b1, 1'b0, 16'h5A5A);
    run_case("R6 zeroing len256", 2'b01, 1'b1, 1'b1, 1'b0, 16'h3C0F);
    run_case("R7 mask off",     2'b10, 1'b0, 1'b1, 1'b0, 16'h0000);
    run_case("R8 broadcast",    2'b10, 1'b0, 1'b0, 1'b1, '1);
    run_case("R8 broadcast masked", 2'b01, 1'b1, 1'b0, 1'b1, 16'h00F3);
    run_case("R1 random",       2'b10, 1'b0, 1'b0, 1'b0, '1);

    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end
endmodule